// File: doc/BRIEF.md
# Dual Performance Counter Unit

This unit keeps two 32-bit event counters for a processor core. Both counters are seen as one 64-bit counter word: the upper counter is in bits 63:32 and the lower counter is in bits 31:0. A second 64-bit word holds the control state. The control word has one event-select field per counter, context enable bits that both counters share, an interrupt enable and two sticky overflow flags. On every clock edge, each counter adds one when two things are true: its selected event is present, and the enable bit for the current privilege level is set.

Software reaches both words through one register port. A write takes effect at the next clock edge. The read data shows the current contents of the selected word without delay. No counter can be stopped on its own. To keep one counter quiet, software selects that counter's park code, which never counts. Software clears all the context enables to stop both counters at once.

Top module: `dual_perf_counter`

## Requirements
- R1: A synchronous active-low reset sets both counters to zero, clears every control bit and holds the interrupt output low.
- R2: The control word uses these bits: bit 0 interrupt enable, bit 1 supervisor enable, bit 2 user enable, bit 3 hypervisor enable, bits 9:4 lower select, bits 16:11 upper select, bit 17 lower overflow flag, bit 18 upper overflow flag. All other bits read as zero. A write takes effect at the next rising edge.
- R3: The upper counter is counter-word bits 63:32 and the lower counter is bits 31:0. The whole 64-bit word is read and written at once. A counter whose event is present and whose context is enabled adds one at each edge.
- R4: Select code 0 counts every clock regardless of the event inputs. Any other code n counts when event_in[n] is high. By convention, code 1 is retired instructions.
- R5: Privilege code 00 is user, 01 is supervisor and 10 is hypervisor. Counting happens only when the enable bit for the current code is set. Code 11 never counts. The enables apply to both counters together.
- R6: Upper code 0x1C and lower code 0x14 are park codes and never count, even when that event input is high. The same code placed in the other counter's field counts normally.
- R7: A counter that steps from 0xFFFFFFFF to 0 sets its overflow flag.
- R8: Writing 0 to an overflow flag clears it. Writing 1 leaves it unchanged and never sets it. A wrap at the same edge as a clearing write leaves the flag set.
- R9: The interrupt output is high exactly when the interrupt enable is set and at least one overflow flag is set.
- R10: A counter-word write at the same edge as an increment loads the written value. That edge then neither adds one nor sets a flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the selected word |
| reg_sel | input | 1 | Word select: 0 control, 1 counters |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Current contents of the selected word |
| event_in | input | 64 | Event inputs, indexed by select code |
| priv_lvl | input | 2 | Current privilege code |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Every register result is due one rising edge after its stimulus. A write shows on the read data after the edge that samples it. An event present before an edge is counted by that edge. The overflow flag and the interrupt change at the same edge as the wrap. The bench changes inputs on the falling edge and reads the design shortly after that falling edge. In a window of N counting cycles it waits exactly N rising edges. The cycle that loads the control word counts under the old, cleared control value, and the bench allows for that.

// File: rtl/dpc_pkg.sv
// Package: shared sizes, control-word layout, privilege codes and per-lane
// constants for the dual performance counter. Lane 0 is the lower counter,
// lane 1 the upper counter.
package dpc_pkg;
    localparam int CNT_W    = 32;
    localparam int SEL_W    = 6;
    localparam int LANES    = 2;
    localparam int REG_W    = LANES * CNT_W;
    localparam int NUM_EVT  = 1 << SEL_W;

    // control word bit positions
    localparam int IRQ_EN_BIT = 0;
    localparam int SUP_EN_BIT = 1;
    localparam int USR_EN_BIT = 2;
    localparam int HV_EN_BIT  = 3;
    localparam int OVF_LSB    = 17;

    localparam logic [SEL_W-1:0] CYCLE_CODE = '0;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_CNT  = 1'b1;

    typedef enum logic [1:0] {
        PRIV_USER = 2'b00,
        PRIV_SUP  = 2'b01,
        PRIV_HV   = 2'b10,
        PRIV_NONE = 2'b11
    } priv_e;

    // low bit of a lane's select field in the control word
    function automatic int sel_lsb(input int lane);
        return (lane == 0) ? 4 : 11;
    endfunction

    // select code that parks a lane
    function automatic logic [SEL_W-1:0] park_code(input int lane);
        return (lane == 0) ? SEL_W'(6'h14) : SEL_W'(6'h1C);
    endfunction
endpackage

// File: rtl/dpc_ctx_gate.sv
// Module: dpc_ctx_gate
// Turns the current privilege code and the three shared context enables
// into one count permission for both lanes.
// Assumes: code 11 is not a valid context and never counts.
module dpc_ctx_gate
    import dpc_pkg::*;
(
    input  logic       usr_en,
    input  logic       sup_en,
    input  logic       hv_en,
    input  logic [1:0] priv_lvl,
    output logic       count_ok
);
    // pick the enable bit that belongs to the current privilege code
    always_comb begin
        case (priv_e'(priv_lvl))
            PRIV_USER: count_ok = usr_en;
            PRIV_SUP:  count_ok = sup_en;
            PRIV_HV:   count_ok = hv_en;
            default:   count_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/dpc_event_pick.sv
// Module: dpc_event_pick
// Selects one lane's event from the event vector. Code CYCLE_CODE is
// always active. The lane's park code is never active, whatever its input.
// Assumes: the event vector has one bit per select code.
module dpc_event_pick
    import dpc_pkg::*;
#(
    parameter int               PICK_W = SEL_W,
    parameter logic [PICK_W-1:0] PARK  = '1,
    localparam int              EVT_N  = 1 << PICK_W
)(
    input  logic [PICK_W-1:0] sel,
    input  logic [EVT_N-1:0]  events,
    output logic              hit
);
    // cycle code first, then park code, then the indexed event bit
    always_comb begin
        if (sel == PICK_W'(CYCLE_CODE))
            hit = 1'b1;
        else if (sel == PARK)
            hit = 1'b0;
        else
            hit = events[sel];
    end
endmodule

// File: rtl/dpc_count_lane.sv
// Module: dpc_count_lane
// One event counter. A load wins over a step at the same edge.
// wrap flags the edge on which a step takes the counter from all ones to zero.
// Assumes: load and step are sampled on the same rising edge.
module dpc_count_lane #(
    parameter int W = 32
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] count,
    output logic         wrap
);
    // counter register: reset, then load, then step
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (step)
            count <= count + W'(1);
    end

    // a step that rolls over and is not overridden by a load
    assign wrap = step & ~load & (&count);
endmodule

// File: rtl/dual_perf_counter.sv
// Module: dual_perf_counter
// Two 32-bit event counters packed into one 64-bit counter word, plus one
// 64-bit control word with per-lane event selects, shared context enables,
// an interrupt enable and sticky per-lane overflow flags.
// Assumes: software parks an idle lane with its park code, because the
// context enables cannot stop one lane alone.
module dual_perf_counter
    import dpc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic               reg_sel,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_EVT-1:0] event_in,
    input  logic [1:0]         priv_lvl,
    output logic               irq_o
);
    logic                 irq_en_q, usr_en_q, sup_en_q, hv_en_q;
    logic [SEL_W-1:0]     sel_q   [LANES];
    logic [CNT_W-1:0]     cnt_val [LANES];
    logic [LANES-1:0]     ovf_q, lane_hit, lane_step, lane_wrap;
    logic                 ctx_ok, ctl_wr, cnt_wr;
    logic [REG_W-1:0]     ctl_word, cnt_word;

    assign ctl_wr = reg_wr_en & (reg_sel == SEL_CTRL);
    assign cnt_wr = reg_wr_en & (reg_sel == SEL_CNT);

    // shared enables and the interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q <= 1'b0;
            usr_en_q <= 1'b0;
            sup_en_q <= 1'b0;
            hv_en_q  <= 1'b0;
        end else if (ctl_wr) begin
            irq_en_q <= reg_wdata[IRQ_EN_BIT];
            usr_en_q <= reg_wdata[USR_EN_BIT];
            sup_en_q <= reg_wdata[SUP_EN_BIT];
            hv_en_q  <= reg_wdata[HV_EN_BIT];
        end
    end

    dpc_ctx_gate u_ctx (
        .usr_en   (usr_en_q),
        .sup_en   (sup_en_q),
        .hv_en    (hv_en_q),
        .priv_lvl (priv_lvl),
        .count_ok (ctx_ok)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int SLSB = sel_lsb(g);

        // lane event select field
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[g] <= '0;
            else if (ctl_wr)
                sel_q[g] <= reg_wdata[SLSB +: SEL_W];
        end

        dpc_event_pick #(
            .PICK_W (SEL_W),
            .PARK   (park_code(g))
        ) u_pick (
            .sel    (sel_q[g]),
            .events (event_in),
            .hit    (lane_hit[g])
        );

        assign lane_step[g] = lane_hit[g] & ctx_ok;

        dpc_count_lane #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (cnt_wr),
            .load_val (reg_wdata[g*CNT_W +: CNT_W]),
            .step     (lane_step[g]),
            .count    (cnt_val[g]),
            .wrap     (lane_wrap[g])
        );

        // sticky flag: a written zero clears it, a wrap sets it and wins
        always_ff @(posedge clk) begin
            if (!rst_n)
                ovf_q[g] <= 1'b0;
            else
                ovf_q[g] <= (ovf_q[g] & ~(ctl_wr & ~reg_wdata[OVF_LSB+g]))
                            | lane_wrap[g];
        end

        assign cnt_word[g*CNT_W +: CNT_W] = cnt_val[g];
    end

    // assemble the control word; unassigned bits read zero
    always_comb begin
        ctl_word             = '0;
        ctl_word[IRQ_EN_BIT] = irq_en_q;
        ctl_word[SUP_EN_BIT] = sup_en_q;
        ctl_word[USR_EN_BIT] = usr_en_q;
        ctl_word[HV_EN_BIT]  = hv_en_q;
        for (int l = 0; l < LANES; l++) begin
            ctl_word[sel_lsb(l) +: SEL_W] = sel_q[l];
            ctl_word[OVF_LSB + l]         = ovf_q[l];
        end
    end

    // read mux for the selected word
    assign reg_rdata = (reg_sel == SEL_CNT) ? cnt_word : ctl_word;

    assign irq_o = irq_en_q & (|ovf_q);
endmodule

// File: rtl/dpc_checker.sv
// Module: dpc_checker
// Property checks for dual_perf_counter, bound to every instance.
// Assumes: lane 0 is the lower half of the counter word.
module dpc_checker
    import dpc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic             reg_sel,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] ctl_word,
    input logic [REG_W-1:0] cnt_word,
    input logic             ctx_ok,
    input logic [LANES-1:0] lane_step,
    input logic             irq_o
);
    logic c_wr, k_wr;
    assign c_wr = reg_wr_en && (reg_sel == SEL_CNT);
    assign k_wr = reg_wr_en && (reg_sel == SEL_CTRL);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctl_word == '0 && cnt_word == '0 && !irq_o));

    assert_lower_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !c_wr |=> cnt_word[CNT_W-1:0] ==
            $past(cnt_word[CNT_W-1:0]) + CNT_W'($past(lane_step[0])));

    assert_upper_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !c_wr |=> cnt_word[REG_W-1:CNT_W] ==
            $past(cnt_word[REG_W-1:CNT_W]) + CNT_W'($past(lane_step[1])));

    assert_ctx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctx_ok && !c_wr) |=> $stable(cnt_word));

    assert_lower_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_word[sel_lsb(0) +: SEL_W] == park_code(0) && !c_wr)
            |=> $stable(cnt_word[CNT_W-1:0]));

    assert_lower_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_wr && lane_step[0] && cnt_word[CNT_W-1:0] == '1)
            |=> ctl_word[OVF_LSB]);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_word[OVF_LSB+1] && !(k_wr && !reg_wdata[OVF_LSB+1]))
            |=> ctl_word[OVF_LSB+1]);

    assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (ctl_word[IRQ_EN_BIT] && |ctl_word[OVF_LSB +: LANES]));

    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr |=> cnt_word == $past(reg_wdata));
endmodule

bind dual_perf_counter dpc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .ctl_word  (ctl_word),
    .cnt_word  (cnt_word),
    .ctx_ok    (ctx_ok),
    .lane_step (lane_step),
    .irq_o     (irq_o)
);

// File: tb/dual_perf_counter_tb.sv
// Bench: dual_perf_counter_tb_top
// Walks a table of counting windows, then directed tests for reset,
// overflow, flag handling and write priority. Inputs change at the
// falling edge; results are read 1 ns after a falling edge.
`timescale 1ns/1ps
module dual_perf_counter_tb_top;
    localparam int WDOG_CYCLES = 20000;
    localparam int NV = 10;

    typedef struct packed {
        logic [7:0]  req;
        logic [31:0] ctrl;
        logic [1:0]  priv;
        logic [63:0] evt;
        logic [7:0]  cyc;
        logic [31:0] exp_hi;
        logic [31:0] exp_lo;
    } vec_t;

    // ctrl: bit2 user, bit1 sup, bit3 hv, sel lower <<4, sel upper <<11
    localparam vec_t VECS [NV] = '{
        '{8'd4, 32'h0000_0004, 2'b00, 64'h0,  8'd5, 32'd5, 32'd5},  // R4 code 0 counts cycles
        '{8'd4, 32'h0000_0804, 2'b00, 64'h0,  8'd5, 32'd0, 32'd5},  // R4 code 1 idle
        '{8'd3, 32'h0000_0894, 2'b00, 64'h202, 8'd4, 32'd4, 32'd4}, // R3 both lanes on events
        '{8'd3, 32'h0000_0894, 2'b00, 64'h2,  8'd3, 32'd3, 32'd0},  // R3 upper only
        '{8'd5, 32'h0000_0004, 2'b01, 64'h0,  8'd5, 32'd0, 32'd0},  // R5 sup not enabled
        '{8'd5, 32'h0000_0002, 2'b01, 64'h0,  8'd6, 32'd6, 32'd6},  // R5 sup enabled
        '{8'd5, 32'h0000_0008, 2'b10, 64'h0,  8'd3, 32'd3, 32'd3},  // R5 hv enabled
        '{8'd5, 32'h0000_000E, 2'b11, 64'h0,  8'd4, 32'd0, 32'd0},  // R5 code 11
        '{8'd6, 32'h0000_E144, 2'b00, '1,     8'd5, 32'd0, 32'd0},  // R6 both parked
        '{8'd6, 32'h0000_A1C4, 2'b00, '1,     8'd5, 32'd5, 32'd5}   // R6 swapped codes count
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [63:0] event_in = '0;
    logic [1:0]  priv_lvl = 2'b00;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dual_perf_counter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .event_in  (event_in),
        .priv_lvl  (priv_lvl),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // called at a falling edge; drives one write across exactly one rising edge
    task automatic wr(input logic s, input logic [63:0] d);
        reg_wr_en = 1'b1;
        reg_sel   = s;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic s, output logic [63:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual %0d cycles expected fewer", WDOG_CYCLES);
        report();
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(1'b0, v); chk("R1", "control after reset", v, 64'h0);
        rd(1'b1, v); chk("R1", "counters after reset", v, 64'h0);
        chk("R1", "irq after reset", {63'h0, irq_o}, 64'h0);

        // table walk: N counting edges per window
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, 64'h0);
            wr(1'b1, 64'h0);
            priv_lvl = VECS[i].priv;
            event_in = VECS[i].evt;
            wr(1'b0, {32'h0, VECS[i].ctrl});
            repeat (int'(VECS[i].cyc)) @(negedge clk);
            rd(1'b1, v);
            chk($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d", i),
                v, {VECS[i].exp_hi, VECS[i].exp_lo});
            event_in = '0;
            priv_lvl = 2'b00;
        end

        // R2 layout: writing all ones keeps only defined fields, flags not set
        wr(1'b0, 64'h0);
        wr(1'b0, '1);
        rd(1'b0, v); chk("R2", "control all-ones readback", v, 64'h0001_FBFF);
        wr(1'b0, 64'h0);

        // R3 whole-word counter write and read with counting off
        wr(1'b1, 64'h0123_4567_89AB_CDEF);
        rd(1'b1, v); chk("R3", "counter word readback", v, 64'h0123_4567_89AB_CDEF);

        // R7 lower wrap, R9 irq
        wr(1'b1, {32'd5, 32'hFFFF_FFFF});
        wr(1'b0, 64'h5);
        @(negedge clk);
        rd(1'b1, v); chk("R7", "lower wrap counters", v, {32'd6, 32'd0});
        rd(1'b0, v); chk("R7", "lower flag set", v[18:17], 64'h1);
        chk("R9", "irq on lower flag", {63'h0, irq_o}, 64'h1);

        // R8 writing 1 keeps flag; R9 irq follows enable
        wr(1'b0, 64'h4 | (64'h1 << 17));
        rd(1'b0, v); chk("R8", "flag kept by written one", v[18:17], 64'h1);
        chk("R9", "irq low with enable clear", {63'h0, irq_o}, 64'h0);
        wr(1'b0, 64'h0);
        rd(1'b0, v); chk("R8", "flag cleared by written zero", v, 64'h0);
        wr(1'b0, 64'h1 | (64'h3 << 17));
        rd(1'b0, v); chk("R8", "written ones do not set flags", v, 64'h1);
        chk("R9", "irq low with no flag", {63'h0, irq_o}, 64'h0);

        // R7 upper wrap sets bit 18
        wr(1'b0, 64'h0);
        wr(1'b1, {32'hFFFF_FFFF, 32'd0});
        wr(1'b0, 64'h5);
        @(negedge clk);
        rd(1'b1, v); chk("R7", "upper wrap counters", v, {32'd0, 32'd1});
        rd(1'b0, v); chk("R7", "upper flag set", v[18:17], 64'h2);
        chk("R9", "irq on upper flag", {63'h0, irq_o}, 64'h1);

        // R10 counter write beats a concurrent step
        wr(1'b0, 64'h0);
        wr(1'b1, 64'h0);
        wr(1'b0, 64'h4);
        wr(1'b1, {32'h10, 32'hFFFF_FFFF});
        rd(1'b1, v); chk("R10", "write wins over step", v, {32'h10, 32'hFFFF_FFFF});
        rd(1'b0, v); chk("R10", "no flag on loaded edge", v[18:17], 64'h0);
        @(negedge clk);
        rd(1'b1, v); chk("R10", "step after load", v, {32'h11, 32'h0});
        rd(1'b0, v); chk("R7", "wrap after load sets flag", v[18:17], 64'h1);

        // R1 reset in the middle of a run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(1'b0, v); chk("R1", "control after late reset", v, 64'h0);
        rd(1'b1, v); chk("R1", "counters after late reset", v, 64'h0);
        chk("R1", "irq after late reset", {63'h0, irq_o}, 64'h0);

        report();
    end
endmodule